// File: doc/BRIEF.md
# Watermarked Word FIFO with Pointer Status

This block is a single-channel circular buffer of 32-bit words. A producer pushes words in and a consumer pops them out. The same block serves both directions of a data channel. In capture, hardware fills it and a host drains it. In playback, a host fills it and hardware drains it.

Software sets two fill levels through one configuration word. The block compares its live occupancy with both levels on every cycle and raises an almost-full flag and an almost-empty flag. It also raises exact full and empty flags. A status word exposes the raw circular read and write addresses, so software can work out the occupied or free space itself. The occupancy and free-space counts are also driven directly.

A pushed word that finds the buffer full is discarded, and so is a pop from an empty buffer. Each discarded access produces a one-cycle pulse. A clear input returns both pointers to address zero. Software asserts it before reprogramming the levels and when it stops streaming service.

Top module: `fwm_fifo`

## Requirements
- R1: After reset the occupancy is 0, the status word is 0, both discard pulses are low, and the flags read 4'b1010 (empty and almost empty set). The reset levels are 511 for almost full and 0 for almost empty.
- R2: Words leave in the order they were written. While the buffer is not empty, `rd_data` shows the oldest stored word in the same cycle.
- R3: `level` equals the number of stored words (0 to 512) and `free` equals 512 minus `level`. Both update in the cycle after an accepted push or pop.
- R4: Flag bit 0 (real full) is set exactly when 512 words are stored. Flag bit 1 (real empty) is set exactly when none are stored.
- R5: Flag bit 2 (almost full) is set when occupancy is at or above the almost-full level, taken from configuration bits 8:0.
- R6: Flag bit 3 (almost empty) is set when occupancy is at or below the almost-empty level, taken from configuration bits 24:16.
- R7: The status word carries the 9-bit read address zero-extended in bits 25:16 and the write address in bits 9:0. All other bits are 0, and each address wraps from 511 to 0.
- R8: A push while real full is discarded and leaves the contents and the write address unchanged. `wr_ovf` is high for the single following cycle. A pop in the same cycle is still accepted.
- R9: A pop while real empty is discarded and leaves the read address unchanged. `rd_unf` is high for the single following cycle. A push in the same cycle is still accepted.
- R10: `clr` sets both addresses to 0 on the next cycle. It overrides any push or pop in the same cycle, and no discard pulse is raised for them.
- R11: A configuration write (`cfg_we`) changes the flag comparison from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empty the buffer (both pointers to 0) |
| cfg_we | input | 1 | Load the level configuration word |
| cfg_word | input | 32 | Almost-empty level in 24:16, almost-full level in 8:0 |
| wr_en | input | 1 | Push request |
| wr_data | input | 32 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 32 | Oldest stored word |
| level | output | 10 | Stored word count |
| free | output | 10 | Free word count |
| flags | output | 4 | {almost empty, almost full, real empty, real full} |
| ptr_status | output | 32 | Read address in 25:16, write address in 9:0 |
| wr_ovf | output | 1 | One-cycle pulse after a discarded push |
| rd_unf | output | 1 | One-cycle pulse after a discarded pop |

## Verification
The assertions check the cycle-level rules on every cycle:
- a discarded push or pop freezes its address and produces exactly one pulse;
- clear always lands on an empty buffer with a zero status word;
- full and empty are never set together;
- occupancy never moves by more than one word per cycle outside a clear;
- full implies almost full, and empty implies almost empty.

Only the bench scenarios can show the following, because they need the bench's word-by-word model:
- data ordering across address wrap;
- the exact threshold crossings for programmed levels;
- the position of each address field;
- the timing of a configuration change.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    // Field layout of the level configuration word
    localparam int LVL_W   = 9;
    localparam int AF_LO   = 0;
    localparam int AE_LO   = 16;

    // Field layout of the pointer status word
    localparam int PF_W    = 10;
    localparam int RD_LO   = 16;
    localparam int WR_LO   = 0;

    // Flag bit positions (software decodes these)
    localparam int FLG_FULL  = 0;
    localparam int FLG_EMPTY = 1;
    localparam int FLG_AF    = 2;
    localparam int FLG_AE    = 3;

    typedef struct packed {
        logic ae;
        logic af;
        logic empty;
        logic full;
    } flags_t;

    typedef struct packed {
        logic [LVL_W-1:0] ae_lvl;
        logic [LVL_W-1:0] af_lvl;
    } marks_t;

    localparam marks_t MARKS_RST = '{ae_lvl: '0, af_lvl: '1};

    function automatic marks_t unpack_marks(input logic [31:0] w);
        marks_t m;
        m.af_lvl = w[AF_LO +: LVL_W];
        m.ae_lvl = w[AE_LO +: LVL_W];
        return m;
    endfunction

    function automatic logic [31:0] pack_status(input logic [PF_W-1:0] ra,
                                                input logic [PF_W-1:0] wa);
        logic [31:0] s;
        s = '0;
        s[RD_LO +: PF_W] = ra;
        s[WR_LO +: PF_W] = wa;
        return s;
    endfunction

endpackage

// File: rtl/fwm_ptr.sv
module fwm_ptr #(
    parameter int AW = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        step,
    output logic [AW:0] ptr
);
    localparam logic [AW:0] ONE = (AW+1)'(1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            ptr <= '0;
        else if (step)
            ptr <= ptr + ONE;
    end
endmodule

// File: rtl/fwm_store.sv
module fwm_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fwm_mark.sv
module fwm_mark
    import fwm_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic   [AW:0] wptr,
    input  logic   [AW:0] rptr,
    input  marks_t        marks,
    output logic   [AW:0] level,
    output flags_t        flg
);
    always_comb begin
        level     = wptr - rptr;
        flg.full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
        flg.empty = (wptr == rptr);
        flg.af    = 32'(level) >= 32'(marks.af_lvl);
        flg.ae    = 32'(level) <= 32'(marks.ae_lvl);
    end
endmodule

// File: rtl/fwm_fifo.sv
module fwm_fifo
    import fwm_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          cfg_we,
    input  logic [31:0]   cfg_word,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [AW:0]   level,
    output logic [AW:0]   free,
    output logic [3:0]    flags,
    output logic [31:0]   ptr_status,
    output logic          wr_ovf,
    output logic          rd_unf
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
    localparam int          WI = 0;
    localparam int          RI = 1;

    marks_t      marks;
    flags_t      flg;
    logic [AW:0] ptrs [2];
    logic        steps [2];
    logic        push_ok, pop_ok;
    logic        cfg_unused_bits;

    assign cfg_unused_bits = ^{cfg_word[31:AE_LO+LVL_W], cfg_word[AE_LO-1:AF_LO+LVL_W]};

    // Level configuration register
    always_ff @(posedge clk) begin
        if (rst)
            marks <= MARKS_RST;
        else if (cfg_we)
            marks <= unpack_marks(cfg_word);
    end

    assign push_ok = wr_en && !flg.full  && !clr;
    assign pop_ok  = rd_en && !flg.empty && !clr;
    assign steps[WI] = push_ok;
    assign steps[RI] = pop_ok;

    // Write and read pointers, each with a wrap bit above the address
    for (genvar g = 0; g < 2; g++) begin : g_ptr
        fwm_ptr #(.AW(AW)) ptr_i (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .step (steps[g]),
            .ptr  (ptrs[g])
        );
    end

    fwm_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) store_i (
        .clk   (clk),
        .we    (push_ok),
        .waddr (ptrs[WI][AW-1:0]),
        .wdata (wr_data),
        .raddr (ptrs[RI][AW-1:0]),
        .rdata (rd_data)
    );

    fwm_mark #(.AW(AW)) mark_i (
        .wptr  (ptrs[WI]),
        .rptr  (ptrs[RI]),
        .marks (marks),
        .level (level),
        .flg   (flg)
    );

    // Discard pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ovf <= 1'b0;
            rd_unf <= 1'b0;
        end else begin
            wr_ovf <= wr_en && flg.full  && !clr;
            rd_unf <= rd_en && flg.empty && !clr;
        end
    end

    assign free       = DEPTH_V - level;
    assign flags      = flg;
    assign ptr_status = pack_status(PF_W'(ptrs[RI][AW-1:0]), PF_W'(ptrs[WI][AW-1:0]));
endmodule

// File: rtl/fwm_chk.sv
module fwm_chk #(
    parameter int DEPTH = 512,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          clr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [LW-1:0] level,
    input logic [3:0]    flags,
    input logic [31:0]   ptr_status,
    input logic          wr_ovf,
    input logic          rd_unf
);
    localparam logic [LW-1:0] ONE = LW'(1);

    assert_full_empty_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(flags[0] && flags[1]));

    assert_full_level_R4: assert property (@(posedge clk) disable iff (rst)
        flags[0] |-> (32'(level) == DEPTH));

    assert_full_is_af_R5: assert property (@(posedge clk) disable iff (rst)
        flags[0] |-> flags[2]);

    assert_empty_is_ae_R6: assert property (@(posedge clk) disable iff (rst)
        flags[1] |-> flags[3]);

    assert_level_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(clr) |-> ((level == $past(level)) || (level == $past(level) + ONE) ||
                         (level + ONE == $past(level))));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && flags[0] && !clr) |=> (wr_ovf && $stable(ptr_status[9:0])));

    assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (rst)
        wr_ovf |-> $past(wr_en));

    assert_no_underrun_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && flags[1] && !clr) |=> (rd_unf && $stable(ptr_status[25:16])));

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (flags[1] && ptr_status == 32'd0 && !wr_ovf && !rd_unf));
endmodule

bind fwm_fifo fwm_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .level      (level),
    .flags      (flags),
    .ptr_status (ptr_status),
    .wr_ovf     (wr_ovf),
    .rd_unf     (rd_unf)
);

// File: tb/fwm_fifo_tb_top.sv
`timescale 1ns/1ps
module fwm_fifo_tb_top;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [9:0]  level;
    logic [9:0]  free;
    logic [3:0]  flags;
    logic [31:0] ptr_status;
    logic        wr_ovf;
    logic        rd_unf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model
    logic [31:0] q[$];
    int rp = 0, wp = 0;
    int af_m = 511, ae_m = 0;
    bit e_ovf = 0, e_unf = 0;

    always #4 clk = ~clk;

    fwm_fifo dut_i (
        .clk(clk), .rst(rst), .clr(clr), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .level(level), .free(free), .flags(flags), .ptr_status(ptr_status),
        .wr_ovf(wr_ovf), .rd_unf(rd_unf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input int r, input int w);
        return 32'((r << 16) | w);
    endfunction

    task automatic check_all();
        int sz = q.size();
        chk("R3 level", 32'(level), 32'(sz));
        chk("R3 free", 32'(free), 32'(DEPTH - sz));
        chk("R4 real full", 32'(flags[0]), 32'(sz == DEPTH));
        chk("R4 real empty", 32'(flags[1]), 32'(sz == 0));
        chk("R5 almost full", 32'(flags[2]), 32'(sz >= af_m));
        chk("R6 almost empty", 32'(flags[3]), 32'(sz <= ae_m));
        chk("R7 pointer status", ptr_status, exp_status(rp, wp));
        chk("R8 push discard pulse", 32'(wr_ovf), 32'(e_ovf));
        chk("R9 pop discard pulse", 32'(rd_unf), 32'(e_unf));
        if (sz > 0) chk("R2 head word", rd_data, q[0]);
    endtask

    // one cycle: inputs held across a rising edge, outputs checked at the falling edge
    task automatic step(input bit w, input logic [31:0] d, input bit r, input bit c,
                        input bit cw, input logic [31:0] cd);
        int sz0;
        wr_en = w; wr_data = d; rd_en = r; clr = c; cfg_we = cw; cfg_word = cd;
        @(posedge clk);
        sz0 = q.size();
        if (c) begin
            q.delete(); rp = 0; wp = 0; e_ovf = 0; e_unf = 0;
        end else begin
            e_ovf = w && (sz0 == DEPTH);
            e_unf = r && (sz0 == 0);
            if (r && sz0 != 0) begin void'(q.pop_front()); rp = (rp + 1) % DEPTH; end
            if (w && sz0 != DEPTH) begin q.push_back(d); wp = (wp + 1) % DEPTH; end
        end
        if (cw) begin af_m = int'(cd[8:0]); ae_m = int'(cd[24:16]); end
        @(negedge clk);
        wr_en = 0; rd_en = 0; clr = 0; cfg_we = 0;
        check_all();
    endtask

    function automatic logic [31:0] mk_cfg(input int af, input int ae);
        return 32'(((ae & 511) << 16) | (af & 511));
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset flags", 32'(flags), 32'h0000000a);
        chk("R1 reset level", 32'(level), 32'd0);
        chk("R1 reset status", ptr_status, 32'd0);
        chk("R1 reset pulses", 32'({wr_ovf, rd_unf}), 32'd0);
        check_all();

        // R11 configuration applies on the following cycle
        step(0, 0, 0, 0, 1, mk_cfg(0, 0));
        chk("R11 almost full with level 0", 32'(flags[2]), 32'd1);
        step(0, 0, 0, 0, 1, mk_cfg(4, 2));
        chk("R11 almost full released", 32'(flags[2]), 32'd0);

        // R5/R6 crossings, one word at a time
        for (int i = 0; i < 6; i++) step(1, $urandom, 0, 0, 0, 0);

        // R9 pop from empty after draining, with a simultaneous push accepted
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(1, 32'hA5A5_0001, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);

        // R4 fill to full, R8 discarded push and push+pop while full
        step(0, 0, 0, 0, 1, mk_cfg(510, 1));
        for (int i = 0; i < DEPTH; i++) step(1, $urandom, 0, 0, 0, 0);
        step(1, 32'hDEAD_BEEF, 0, 0, 0, 0);
        step(1, 32'h1234_5678, 1, 0, 0, 0);
        // R7 drain across the wrap of both addresses
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 0, 0, 0);

        // R10 clear overrides a simultaneous push and pop
        for (int i = 0; i < 5; i++) step(1, $urandom, 0, 0, 0, 0);
        step(1, 32'h0BAD_0BAD, 1, 1, 0, 0);
        chk("R10 clear empties", 32'(level), 32'd0);
        step(0, 0, 1, 1, 0, 0);
        chk("R10 no pulse on clear", 32'(rd_unf), 32'd0);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int bias = (i / 500) % 2;
            bit w  = ($urandom % 100) < (bias ? 70 : 35);
            bit r  = ($urandom % 100) < (bias ? 35 : 70);
            bit c  = ($urandom % 300) == 0;
            bit cw = ($urandom % 60) == 0;
            step(w, $urandom, r, c, cw, mk_cfg($urandom % 512, $urandom % 512));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule